// File: doc/BRIEF.md
# Software-Increment Write Trap Arbiter

This block decides what happens when code running at one of four privilege levels (0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor) writes the performance-monitor software-increment register from the 32-bit execution state. It reads the current level and the control bits that can gate the access. From these it selects exactly one outcome: the write goes ahead, an undefined-instruction exception is raised, or the access traps to a higher level with a syndrome class.

The trap conditions are checked in a fixed order, and the first one that matches decides the outcome. Which conditions take part depends on the current level. Level 0 sees the longest list, level 2 sees only the monitor checks, and level 3 always writes. A hypervisor host-mode flag removes some level-0 conditions from the list. The decision is computed combinationally and registered once, so it appears one clock after the inputs.

Top module: `pmu_incr_trap_arb`

## Requirements
- R1: When `pm_feat` or `narrow_feat` is low, the outcome is undefined at every level. This check takes priority over every other rule, including R2.
- R2: When both features are present and `cur_lvl` is 3, the outcome is write, whatever the trap-control bits are.
- R3: At levels 0 to 2, with level 3 implemented as 64-bit (`lvl_impl[3]`=1, `lvl_narrow[3]`=0), `mon_pm_trap` and `sdd_undef_prio` both high give undefined. This rule is checked ahead of every rule below.
- R4: At level 0 with a 64-bit level 1, the user gate is closed when `user_en` is 000 (with `user_en_ext`=1) or when `user_en[1:0]` is 00 (with `user_en_ext`=0). A closed gate traps with class 0x03. The target is level 2 when level 2 is 64-bit and `hyp_route_all` is set, and level 1 otherwise.
- R5: At level 0 with a 32-bit level 1 and `user_en[1:0]`=00, the outcome depends on `hyp_route_all` and level 2. With `hyp_route_all` set and a 64-bit level 2, it traps to level 2 with class 0x03. With `hyp_route_all` set and a 32-bit level 2, it traps to level 2 with class 0x00. Otherwise it is undefined.
- R6: At levels 0 and 1, `hyp_grp_trap` traps to level 2 with class 0x03 when level 2 is implemented. With a 64-bit level 2 at level 0, `host_mode` suppresses this rule. The rule is checked after R4/R5 and before R7 to R9.
- R7: The fine-grained write trap (`fgt_feat` and `fgt_wr_trap`) traps to level 2 with class 0x03. It applies only when all of these hold: the current level is 0, `host_mode` is low, level 1 is 64-bit, level 2 is implemented, and either level 3 is absent or `fgt_mon_en` is set.
- R8: At levels 0 and 1, `hyp_pm_trap` traps to level 2 with class 0x03 when level 2 is implemented. At level 2 the bit has no effect.
- R9: At levels 0 to 2 with a 64-bit level 3, `mon_pm_trap` is checked last. It traps to level 3 with class 0x03, or gives undefined when `sdd_undef` is high.
- R10: When no rule matches, the outcome is write. `outc` is always one-hot: bit 0 = write, bit 1 = undefined, bit 2 = trap. Write and undefined outcomes carry `tgt_lvl`=0 and `syn_cls`=0.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, the outputs are write, level 0 and class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | 2 | Level the access comes from |
| pm_feat | input | 1 | Performance-monitor feature present |
| narrow_feat | input | 1 | 32-bit execution state present |
| lvl_impl | input | 4 | Per-level implemented flag (bit n = level n) |
| lvl_narrow | input | 4 | Per-level flag: level n runs in 32-bit state |
| user_en_ext | input | 1 | Extended user-enable control present |
| user_en | input | 3 | User enables: [2] extended, [1] increment, [0] general |
| hyp_route_all | input | 1 | Hypervisor routes all level-0 exceptions to itself |
| hyp_grp_trap | input | 1 | Hypervisor register-group trap |
| hyp_pm_trap | input | 1 | Hypervisor performance-monitor trap |
| mon_pm_trap | input | 1 | Monitor performance-monitor trap |
| host_mode | input | 1 | Hypervisor host mode active for level 0 |
| fgt_feat | input | 1 | Fine-grained trap feature present |
| fgt_mon_en | input | 1 | Monitor enable for fine-grained traps |
| fgt_wr_trap | input | 1 | Fine-grained write-trap bit for this register |
| sdd_undef_prio | input | 1 | Secure-debug undefined takes priority |
| sdd_undef | input | 1 | Secure-debug undefined instead of monitor trap |
| outc | output | 3 | One-hot outcome: [0] write, [1] undefined, [2] trap |
| tgt_lvl | output | 2 | Trap target level |
| syn_cls | output | 6 | Trap syndrome class |

## Verification
The assertions check on every cycle that exactly one outcome is raised, and that write and undefined outcomes carry no target or class. They also check that a trap always targets a level above the source level, and that a level-3 trap only follows a set monitor bit. The feature-absent, top-level and secure-debug priority cases are checked as well. The bench scenarios cover the rest. They show the ordering of each pair of rules in both directions, including cases where both rules would trap to the same level but only the earlier rule's class or condition can apply. They also cover host-mode and level-3 masking of the fine-grained trap, the 32-bit and 64-bit routing variants, and the one-cycle latency.

// File: rtl/pita_pkg.sv
package pita_pkg;

    localparam int NUM_LVL   = 4;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int CLS_W     = 6;
    localparam int NUM_RULES = 11;
    localparam int OC_W      = 3;

    localparam logic [CLS_W-1:0] CLS_SYS   = 6'h03;
    localparam logic [CLS_W-1:0] CLS_HYP32 = 6'h00;

    typedef enum logic [1:0] {
        OC_WRITE = 2'd0,
        OC_UNDEF = 2'd1,
        OC_TRAP  = 2'd2
    } oc_e;

    typedef struct packed {
        oc_e              oc;
        logic [LVL_W-1:0] tgt;
        logic [CLS_W-1:0] cls;
    } dec_t;

    // Rule positions: index order is priority order (0 first).
    localparam int RL_NOFEAT = 0;
    localparam int RL_TOP    = 1;
    localparam int RL_SDDP   = 2;
    localparam int RL_USR64  = 3;
    localparam int RL_USR32  = 4;
    localparam int RL_GRP64  = 5;
    localparam int RL_GRP32  = 6;
    localparam int RL_FGT    = 7;
    localparam int RL_HPM64  = 8;
    localparam int RL_HPM32  = 9;
    localparam int RL_MPM    = 10;

    function automatic dec_t mk(oc_e oc, logic [LVL_W-1:0] tgt, logic [CLS_W-1:0] cls);
        dec_t d;
        d.oc  = oc;
        d.tgt = tgt;
        d.cls = cls;
        return d;
    endfunction

endpackage

// File: rtl/pita_rule_eval.sv
module pita_rule_eval
    import pita_pkg::*;
#(
    parameter int NR = NUM_RULES
) (
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               pm_feat,
    input  logic               narrow_feat,
    input  logic [NUM_LVL-1:0] lvl_impl,
    input  logic [NUM_LVL-1:0] lvl_narrow,
    input  logic               user_en_ext,
    input  logic [2:0]         user_en,
    input  logic               hyp_route_all,
    input  logic               hyp_grp_trap,
    input  logic               hyp_pm_trap,
    input  logic               mon_pm_trap,
    input  logic               host_mode,
    input  logic               fgt_feat,
    input  logic               fgt_mon_en,
    input  logic               fgt_wr_trap,
    input  logic               sdd_undef_prio,
    input  logic               sdd_undef,
    output logic [NR-1:0]      hit,
    output dec_t [NR-1:0]      res
);

    logic [NUM_LVL-1:0] wide;
    logic [NUM_LVL-1:0] thin;
    logic at0, at01, below_top, gate64_off, gate32_off, hyp_route64, hyp_route32;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign wide[l] = lvl_impl[l] & ~lvl_narrow[l];
        assign thin[l] = lvl_impl[l] &  lvl_narrow[l];
    end

    assign at0         = (cur_lvl == LVL_W'(0));
    assign at01        = (cur_lvl <= LVL_W'(1));
    assign below_top   = (cur_lvl != LVL_W'(NUM_LVL-1));
    assign gate64_off  = user_en_ext ? (user_en == 3'b000) : (user_en[1:0] == 2'b00);
    assign gate32_off  = (user_en[1:0] == 2'b00);
    assign hyp_route64 = wide[2] & hyp_route_all;
    assign hyp_route32 = thin[2] & hyp_route_all;

    always_comb begin
        hit           = '0;
        hit[RL_NOFEAT] = ~(pm_feat & narrow_feat);
        hit[RL_TOP]    = ~below_top;
        hit[RL_SDDP]   = below_top & wide[3] & mon_pm_trap & sdd_undef_prio;
        hit[RL_USR64]  = at0 & wide[1] & gate64_off;
        hit[RL_USR32]  = at0 & thin[1] & gate32_off;
        hit[RL_GRP64]  = at01 & wide[2] & hyp_grp_trap & ~(at0 & host_mode);
        hit[RL_GRP32]  = at01 & thin[2] & hyp_grp_trap;
        hit[RL_FGT]    = at0 & lvl_impl[2] & wide[1] & ~host_mode & fgt_feat
                       & (~lvl_impl[3] | fgt_mon_en) & fgt_wr_trap;
        hit[RL_HPM64]  = at01 & wide[2] & hyp_pm_trap;
        hit[RL_HPM32]  = at01 & thin[2] & hyp_pm_trap;
        hit[RL_MPM]    = below_top & wide[3] & mon_pm_trap;
    end

    always_comb begin
        for (int i = 0; i < NR; i++) res[i] = mk(OC_TRAP, LVL_W'(2), CLS_SYS);
        res[RL_NOFEAT] = mk(OC_UNDEF, '0, '0);
        res[RL_TOP]    = mk(OC_WRITE, '0, '0);
        res[RL_SDDP]   = mk(OC_UNDEF, '0, '0);
        res[RL_USR64]  = mk(OC_TRAP, hyp_route64 ? LVL_W'(2) : LVL_W'(1), CLS_SYS);
        if (hyp_route64)      res[RL_USR32] = mk(OC_TRAP, LVL_W'(2), CLS_SYS);
        else if (hyp_route32) res[RL_USR32] = mk(OC_TRAP, LVL_W'(2), CLS_HYP32);
        else                  res[RL_USR32] = mk(OC_UNDEF, '0, '0);
        res[RL_MPM]    = sdd_undef ? mk(OC_UNDEF, '0, '0) : mk(OC_TRAP, LVL_W'(3), CLS_SYS);
    end

endmodule

// File: rtl/pita_first_match.sv
module pita_first_match
    import pita_pkg::*;
#(
    parameter int NR = NUM_RULES
) (
    input  logic [NR-1:0] hit,
    input  dec_t [NR-1:0] res,
    output dec_t          sel
);

    // Chain from the lowest-priority rule upward; stage 0 is the winner.
    dec_t chain [NR+1];

    assign chain[NR] = mk(OC_WRITE, '0, '0);

    for (genvar i = NR - 1; i >= 0; i--) begin : g_stage
        assign chain[i] = hit[i] ? res[i] : chain[i+1];
    end

    assign sel = chain[0];

endmodule

// File: rtl/pmu_incr_trap_arb.sv
module pmu_incr_trap_arb
    import pita_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               pm_feat,
    input  logic               narrow_feat,
    input  logic [NUM_LVL-1:0] lvl_impl,
    input  logic [NUM_LVL-1:0] lvl_narrow,
    input  logic               user_en_ext,
    input  logic [2:0]         user_en,
    input  logic               hyp_route_all,
    input  logic               hyp_grp_trap,
    input  logic               hyp_pm_trap,
    input  logic               mon_pm_trap,
    input  logic               host_mode,
    input  logic               fgt_feat,
    input  logic               fgt_mon_en,
    input  logic               fgt_wr_trap,
    input  logic               sdd_undef_prio,
    input  logic               sdd_undef,
    output logic [OC_W-1:0]    outc,
    output logic [LVL_W-1:0]   tgt_lvl,
    output logic [CLS_W-1:0]   syn_cls
);

    logic [NUM_RULES-1:0] hit;
    dec_t [NUM_RULES-1:0] res;
    dec_t sel;
    dec_t dec_d, dec_q;

    pita_rule_eval #(.NR(NUM_RULES)) u_eval (
        .cur_lvl        (cur_lvl),
        .pm_feat        (pm_feat),
        .narrow_feat    (narrow_feat),
        .lvl_impl       (lvl_impl),
        .lvl_narrow     (lvl_narrow),
        .user_en_ext    (user_en_ext),
        .user_en        (user_en),
        .hyp_route_all  (hyp_route_all),
        .hyp_grp_trap   (hyp_grp_trap),
        .hyp_pm_trap    (hyp_pm_trap),
        .mon_pm_trap    (mon_pm_trap),
        .host_mode      (host_mode),
        .fgt_feat       (fgt_feat),
        .fgt_mon_en     (fgt_mon_en),
        .fgt_wr_trap    (fgt_wr_trap),
        .sdd_undef_prio (sdd_undef_prio),
        .sdd_undef      (sdd_undef),
        .hit            (hit),
        .res            (res)
    );

    pita_first_match #(.NR(NUM_RULES)) u_pick (
        .hit (hit),
        .res (res),
        .sel (sel)
    );

    always_comb begin
        dec_d = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= mk(OC_WRITE, '0, '0);
        else        dec_q <= dec_d;
    end

    assign outc    = {dec_q.oc == OC_TRAP, dec_q.oc == OC_UNDEF, dec_q.oc == OC_WRITE};
    assign tgt_lvl = dec_q.tgt;
    assign syn_cls = dec_q.cls;

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(outc) == 1);

    assert_quiet_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !outc[2] |-> (tgt_lvl == '0 && syn_cls == '0));

    assert_nofeat_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_feat && narrow_feat) |=> outc == 3'b010);

    assert_top_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_feat && narrow_feat && cur_lvl == LVL_W'(3)) |=> outc == 3'b001);

    assert_sdd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_feat && narrow_feat && cur_lvl != LVL_W'(3) && lvl_impl[3] && !lvl_narrow[3]
         && mon_pm_trap && sdd_undef_prio) |=> outc == 3'b010);

    assert_trap_upward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        outc[2] |-> tgt_lvl > $past(cur_lvl));

    assert_lvl3_needs_mon_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_pm_trap |=> !(outc[2] && tgt_lvl == LVL_W'(3)));

endmodule

// File: tb/pmu_incr_trap_arb_tb.sv
module pmu_incr_trap_arb_tb;

    localparam logic [2:0] W = 3'b001;
    localparam logic [2:0] U = 3'b010;
    localparam logic [2:0] T = 3'b100;

    // Stimulus fields are stored so that the common setting is zero:
    // *_off = feature/level absent, wid = level runs 32-bit, uen_n = inverted enables.
    typedef struct packed {
        logic [1:0] cur;
        logic       pm_off, nar_off;
        logic [3:0] impl_off, wid;
        logic       ext;
        logic [2:0] uen_n;
        logic       route, grp, hpm, mpm, host, fgtp, fgtme, fgtw, sddp, sdd;
        logic [2:0] e_out;
        logic [1:0] e_tgt;
        logic [5:0] e_cls;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{default:0, cur:2'd0, e_out:W, req:4'd10},                                           // R10 nothing set
        '{default:0, cur:2'd0, pm_off:1, e_out:U, req:4'd1},                                  // R1
        '{default:0, cur:2'd3, nar_off:1, e_out:U, req:4'd1},                                 // R1 beats R2
        '{default:0, cur:2'd3, mpm:1, sddp:1, hpm:1, grp:1, uen_n:3'b111, e_out:W, req:4'd2}, // R2
        '{default:0, cur:2'd0, mpm:1, sddp:1, e_out:U, req:4'd3},                             // R3
        '{default:0, cur:2'd2, mpm:1, sddp:1, e_out:U, req:4'd3},                             // R3
        '{default:0, cur:2'd0, mpm:1, sddp:1, uen_n:3'b111, e_out:U, req:4'd3},               // R3 before R4
        '{default:0, cur:2'd0, mpm:1, uen_n:3'b111, e_out:T, e_tgt:2'd1, e_cls:6'h03, req:4'd4}, // R4 before R9
        '{default:0, cur:2'd0, uen_n:3'b111, e_out:T, e_tgt:2'd1, e_cls:6'h03, req:4'd4},     // R4
        '{default:0, cur:2'd0, uen_n:3'b111, route:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd4},
        '{default:0, cur:2'd0, ext:0, uen_n:3'b011, e_out:T, e_tgt:2'd1, e_cls:6'h03, req:4'd4},
        '{default:0, cur:2'd0, ext:1, uen_n:3'b011, e_out:W, req:4'd4},
        '{default:0, cur:2'd0, uen_n:3'b111, grp:1, e_out:T, e_tgt:2'd1, e_cls:6'h03, req:4'd4}, // R4 before R6
        '{default:0, cur:2'd0, impl_off:4'b0010, uen_n:3'b111, e_out:W, req:4'd4},            // R4 needs level 1
        '{default:0, cur:2'd0, wid:4'b0010, uen_n:3'b111, e_out:U, req:4'd5},                 // R5
        '{default:0, cur:2'd0, wid:4'b0010, uen_n:3'b111, route:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd5},
        '{default:0, cur:2'd0, wid:4'b0110, uen_n:3'b111, route:1, e_out:T, e_tgt:2'd2, e_cls:6'h00, req:4'd5},
        '{default:0, cur:2'd1, wid:4'b0010, uen_n:3'b111, e_out:W, req:4'd5},                 // R5 level 0 only
        '{default:0, cur:2'd0, grp:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd6},            // R6
        '{default:0, cur:2'd0, grp:1, host:1, e_out:W, req:4'd6},
        '{default:0, cur:2'd1, grp:1, host:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd6},
        '{default:0, cur:2'd1, wid:4'b0100, grp:1, host:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd6},
        '{default:0, cur:2'd2, grp:1, e_out:W, req:4'd6},
        '{default:0, cur:2'd1, grp:1, mpm:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd6},     // R6 before R9
        '{default:0, cur:2'd0, fgtp:1, fgtw:1, e_out:W, req:4'd7},                            // R7 blocked by level 3
        '{default:0, cur:2'd0, fgtp:1, fgtw:1, fgtme:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd7},
        '{default:0, cur:2'd0, impl_off:4'b1000, fgtp:1, fgtw:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd7},
        '{default:0, cur:2'd1, fgtp:1, fgtw:1, fgtme:1, e_out:W, req:4'd7},
        '{default:0, cur:2'd0, fgtp:1, fgtw:1, fgtme:1, host:1, e_out:W, req:4'd7},
        '{default:0, cur:2'd0, fgtw:1, fgtme:1, e_out:W, req:4'd7},
        '{default:0, cur:2'd0, fgtp:1, fgtw:1, fgtme:1, mpm:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd7}, // R7 before R9
        '{default:0, cur:2'd1, hpm:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd8},            // R8
        '{default:0, cur:2'd2, hpm:1, e_out:W, req:4'd8},
        '{default:0, cur:2'd1, impl_off:4'b0100, hpm:1, e_out:W, req:4'd8},
        '{default:0, cur:2'd1, wid:4'b0100, hpm:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd8},
        '{default:0, cur:2'd1, hpm:1, mpm:1, e_out:T, e_tgt:2'd2, e_cls:6'h03, req:4'd8},     // R8 before R9
        '{default:0, cur:2'd1, mpm:1, e_out:T, e_tgt:2'd3, e_cls:6'h03, req:4'd9},            // R9
        '{default:0, cur:2'd1, mpm:1, sdd:1, e_out:U, req:4'd9},
        '{default:0, cur:2'd2, mpm:1, e_out:T, e_tgt:2'd3, e_cls:6'h03, req:4'd9},
        '{default:0, cur:2'd1, wid:4'b1000, mpm:1, sddp:1, e_out:W, req:4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cur_lvl;
    logic pm_feat, narrow_feat, user_en_ext, hyp_route_all, hyp_grp_trap, hyp_pm_trap;
    logic mon_pm_trap, host_mode, fgt_feat, fgt_mon_en, fgt_wr_trap, sdd_undef_prio, sdd_undef;
    logic [3:0] lvl_impl, lvl_narrow;
    logic [2:0] user_en;
    logic [2:0] outc;
    logic [1:0] tgt_lvl;
    logic [5:0] syn_cls;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pmu_incr_trap_arb u_dut (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .pm_feat(pm_feat),
        .narrow_feat(narrow_feat), .lvl_impl(lvl_impl), .lvl_narrow(lvl_narrow),
        .user_en_ext(user_en_ext), .user_en(user_en), .hyp_route_all(hyp_route_all),
        .hyp_grp_trap(hyp_grp_trap), .hyp_pm_trap(hyp_pm_trap), .mon_pm_trap(mon_pm_trap),
        .host_mode(host_mode), .fgt_feat(fgt_feat), .fgt_mon_en(fgt_mon_en),
        .fgt_wr_trap(fgt_wr_trap), .sdd_undef_prio(sdd_undef_prio), .sdd_undef(sdd_undef),
        .outc(outc), .tgt_lvl(tgt_lvl), .syn_cls(syn_cls)
    );

    task automatic apply(input vec_t v);
        cur_lvl        = v.cur;
        pm_feat        = ~v.pm_off;
        narrow_feat    = ~v.nar_off;
        lvl_impl       = ~v.impl_off;
        lvl_narrow     = v.wid;
        user_en_ext    = v.ext;
        user_en        = ~v.uen_n;
        hyp_route_all  = v.route;
        hyp_grp_trap   = v.grp;
        hyp_pm_trap    = v.hpm;
        mon_pm_trap    = v.mpm;
        host_mode      = v.host;
        fgt_feat       = v.fgtp;
        fgt_mon_en     = v.fgtme;
        fgt_wr_trap    = v.fgtw;
        sdd_undef_prio = v.sddp;
        sdd_undef      = v.sdd;
    endtask

    task automatic check(input string tag, input logic [2:0] eo, input logic [1:0] et,
                         input logic [5:0] ec);
        checks++;
        if (outc !== eo || tgt_lvl !== et || syn_cls !== ec) begin
            errors++;
            $display("FAIL %s: got outc=%b tgt=%0d cls=%h, expected outc=%b tgt=%0d cls=%h",
                     tag, outc, tgt_lvl, syn_cls, eo, et, ec);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t trapv;
        apply(VECS[36]);
        repeat (2) @(negedge clk);
        check("R11 reset state", W, 2'd0, 6'h00);

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].e_out, VECS[i].e_tgt, VECS[i].e_cls);
        end

        // R11: output holds the earlier decision until the next rising edge.
        @(negedge clk);
        apply(VECS[0]);
        @(negedge clk);
        trapv = VECS[36];
        apply(trapv);
        #1;
        check("R11 no change before edge", W, 2'd0, 6'h00);
        @(negedge clk);
        check("R11 updated after edge", T, 2'd3, 6'h03);

        // R11: reset mid-run returns to the write state.
        #1 rst_n = 1'b0;
        #1;
        check("R11 async reset", W, 2'd0, 6'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 resume after reset", T, 2'd3, 6'h03);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule